// File: doc/BRIEF.md
# Decade Rate Multiplier

This block divides its clock into repeating ten-cycle frames and, in each frame, emits as many single-cycle output pulses as a four-bit decimal rate word asks for. Inside it, a modulo-ten counter walks through states 0 to 9. Each bit of the rate word owns a fixed set of counter states: the weight-1 bit owns one state, the weight-2 bit two, the weight-4 bit four and the weight-8 bit eight. A state produces a pulse when its owning bit is set. In decimal codes the owned sets never meet, so their pulse counts add.

Decades chain through an inhibit input and a carry output. A following stage whose inhibit is fed by this stage's carry advances once per ten clocks. When the true outputs of two such stages are ORed, the pulse rate is Clock × (0.1·D1 + 0.01·D2). A strobe input blanks the output. A cascade input forces the output high so that another stage's pulses can be merged in. A terminal-count output shows state nine.

Top module: `decade_rate_mult`

## Requirements
- R1: For a rate code N from 0 to 9, with no override active, `out_o` is high in exactly N of any 10 consecutive clock cycles.
- R2: Rate codes 10 to 15 are accepted. Codes 10, 12 and 14 give 8 pulses per 10 clocks, and codes 11, 13 and 15 give 9.
- R3: The counter counts 0,1,…,9,0 and advances once per clock while not inhibited. After a clear, `nine_o` is first high after the 9th following clock and then every 10 clocks.
- R4: `clr_i` loads state 0 at the next edge and `set9_i` loads state 9 at the next edge, both synchronously. When both are high, clear wins.
- R5: While `inh_i` is high, the counter holds its state and `out_o` is low one cycle later (unless cascade is high). Clear and set still load.
- R6: While `strobe_i` is high, `out_o` is low one cycle later (unless cascade is high), and the counter keeps advancing.
- R7: `cascade_i` high forces `out_o` high one cycle later, overriding strobe and inhibit.
- R8: `nine_o` is high exactly while the counter holds state 9.
- R9: `inh_o` is low only when the counter is at state 9 and `inh_i` is low. A second stage with its inhibit driven from `inh_o` advances once per ten clocks. With digits 9 and 4, the ORed outputs give 94 pulses in 100 clocks (90 from the first stage and 4 from the second).
- R10: `out_n_o` is always the inverse of `out_o`, including during reset.
- R11: Synchronous active-high `rst` sets the counter to 0, `out_o` low and `out_n_o` high.
- R12: State ownership is as follows. The weight-1 bit owns state 8. The weight-2 bit owns states 1 and 5. The weight-4 bit owns states 0, 2, 4 and 6. The weight-8 bit owns states 0 to 7. `out_o` goes high in the cycle after an edge at which the counter held an owned state. So with code 1, `out_o` is high exactly when `nine_o` is high, and with code 8, `out_o` is never high together with `nine_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_i | input | 4 | Rate code; bit 0 has weight 1, bit 3 has weight 8 |
| clr_i | input | 1 | Synchronous load of state 0 |
| set9_i | input | 1 | Synchronous load of state 9 |
| inh_i | input | 1 | Inhibit / carry in: freezes counter, blanks output |
| strobe_i | input | 1 | Blanks the rate output |
| cascade_i | input | 1 | Forces the true rate output high |
| out_o | output | 1 | Registered true rate output |
| out_n_o | output | 1 | Registered complementary rate output |
| nine_o | output | 1 | High in state nine |
| inh_o | output | 1 | Inhibit / carry out to the next decade |

## Verification
The bench uses the default package constants: modulus ten and a four-bit rate word. These are the values that make the ownership map cover every decimal code without overlap. It instantiates two copies, the second inhibited by the first's carry. This makes the hundred-clock add-mode total and the once-per-hundred carry reachable. It also reaches every code from 0 to 15, including the six non-decimal codes where the weight-2 and weight-4 states fall inside the weight-8 states.

// File: rtl/drm_pkg.sv
package drm_pkg;
  localparam int unsigned DEC_MOD = 10;
  localparam int unsigned CNT_W   = $clog2(DEC_MOD);
  localparam int unsigned RATE_W  = 4;

  // Counter states owned by each rate bit. Weight 8 and weight 1 never share,
  // weights 2 and 4 sit inside weight 8 but apart from each other.
  function automatic logic slot_owned(input int unsigned wbit,
                                      input logic [CNT_W-1:0] s);
    logic r;
    r = 1'b0;
    case (wbit)
      0: r = (s == CNT_W'(8));
      1: r = (s == CNT_W'(1)) || (s == CNT_W'(5));
      2: r = !s[0] && (s <= CNT_W'(6));
      3: r = (s <= CNT_W'(7));
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/drm_decade_counter.sv
module drm_decade_counter #(
  parameter int unsigned MOD = drm_pkg::DEC_MOD,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         set_term,
  input  logic         hold,
  output logic [W-1:0] state,
  output logic         at_term
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)      state <= '0;
    else if (set_term)   state <= LAST;
    else if (!hold)      state <= (state == LAST) ? '0 : state + 1'b1;
  end

  assign at_term = (state == LAST);

  p_state_range_r3: assert property (@(posedge clk) disable iff (rst)
    state <= LAST);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (at_term && !hold && !clr && !set_term) |=> (state == '0));
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (state == '0));
  p_set_term_r4: assert property (@(posedge clk) disable iff (rst)
    (set_term && !clr) |=> at_term);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr && !set_term) |=> $stable(state));
endmodule

// File: rtl/drm_rate_select.sv
module drm_rate_select #(
  parameter int unsigned RW = drm_pkg::RATE_W,
  parameter int unsigned SW = drm_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] state,
  input  logic [RW-1:0] rate,
  output logic          hit
);
  logic [RW-1:0] lane;

  for (genvar i = 0; i < RW; i++) begin : g_lane
    assign lane[i] = rate[i] & drm_pkg::slot_owned(i, state);
  end

  assign hit = |lane;

  // Decimal codes must never have two weights claim the same state.
  p_slot_disjoint_r1: assert property (@(posedge clk) disable iff (rst)
    (rate <= RW'(9)) |-> $onehot0(lane));
endmodule

// File: rtl/decade_rate_mult.sv
module decade_rate_mult (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rate_i,
  input  logic       clr_i,
  input  logic       set9_i,
  input  logic       inh_i,
  input  logic       strobe_i,
  input  logic       cascade_i,
  output logic       out_o,
  output logic       out_n_o,
  output logic       nine_o,
  output logic       inh_o
);
  import drm_pkg::*;

  logic [CNT_W-1:0] state;
  logic             at_term;
  logic             hit;
  logic             pulse_nxt;

  drm_decade_counter #(.MOD(DEC_MOD), .W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_i), .set_term(set9_i), .hold(inh_i),
    .state(state), .at_term(at_term)
  );

  drm_rate_select #(.RW(RATE_W), .SW(CNT_W)) u_sel (
    .clk(clk), .rst(rst), .state(state), .rate(rate_i), .hit(hit)
  );

  assign pulse_nxt = cascade_i | (hit & ~inh_i & ~strobe_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_o   <= 1'b0;
      out_n_o <= 1'b1;
    end else begin
      out_o   <= pulse_nxt;
      out_n_o <= ~pulse_nxt;
    end
  end

  assign nine_o = at_term;
  assign inh_o  = inh_i | ~at_term;

  p_cascade_r7: assert property (@(posedge clk) disable iff (rst)
    cascade_i |=> out_o);
  p_strobe_blank_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !cascade_i) |=> !out_o);
  p_inhibit_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (inh_i && !cascade_i) |=> !out_o);
  p_complement_r10: assert property (@(posedge clk) disable iff (rst)
    out_n_o != out_o);
  p_carry_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (!inh_o && !set9_i) |=> !nine_o);
endmodule

// File: tb/decade_rate_mult_tb.sv
module decade_rate_mult_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rate = '0, rate_lo = '0;
  logic       clr = 0, set9 = 0, inh = 0, strobe = 0, cas = 0;
  logic       out, out_n, nine, inh_out;
  logic       out_lo, out_n_lo, nine_lo, inh_out_lo;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  decade_rate_mult dut_i (
    .clk(clk), .rst(rst), .rate_i(rate), .clr_i(clr), .set9_i(set9),
    .inh_i(inh), .strobe_i(strobe), .cascade_i(cas),
    .out_o(out), .out_n_o(out_n), .nine_o(nine), .inh_o(inh_out)
  );

  decade_rate_mult dut_lo (
    .clk(clk), .rst(rst), .rate_i(rate_lo), .clr_i(clr), .set9_i(1'b0),
    .inh_i(inh_out), .strobe_i(1'b0), .cascade_i(1'b0),
    .out_o(out_lo), .out_n_o(out_n_lo), .nine_o(nine_lo), .inh_o(inh_out_lo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr = 1; tick(); clr = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick();
    check(out == 0 && out_n == 1, "R11 out/out_n in reset", {out, out_n}, 1);
    check(nine == 0 && inh_out == 1, "R11 counter zero in reset", {nine, inh_out}, 1);
    check(out_n == ~out, "R10 complement in reset", out_n, ~out);
    rst = 0;
  endtask

  task automatic t_rate_sweep();
    for (int code = 0; code < 16; code++) begin
      int exp_n, bad_n;
      exp_n = (code < 10) ? code : ((code % 2) ? 9 : 8);
      bad_n = 0;
      rate = 4'(code);
      clear_all();
      for (int w = 0; w < 5; w++) begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
          tick();
          cnt += int'(out);
          if (out_n == out) bad_n++;
        end
        check(cnt == exp_n, (code < 10) ? "R1 pulses per window" : "R2 non-decimal pulses",
              cnt, exp_n);
      end
      check(bad_n == 0, "R10 complement during sweep", bad_n, 0);
    end
  endtask

  task automatic t_slots();
    int bad;
    bad = 0; rate = 4'd1; clear_all();
    for (int k = 0; k < 30; k++) begin tick(); if (out != nine) bad++; end
    check(bad == 0, "R12 weight-1 slot aligns with nine", bad, 0);
    bad = 0; rate = 4'd8; clear_all();
    for (int k = 0; k < 30; k++) begin tick(); if (out && nine) bad++; end
    check(bad == 0, "R12 weight-8 slot avoids state nine", bad, 0);
  endtask

  task automatic t_counter();
    int first, second;
    first = -1; second = -1;
    clear_all();
    for (int k = 1; k <= 20; k++) begin
      tick();
      if (nine) begin
        if (first < 0) first = k; else if (second < 0) second = k;
      end
    end
    check(first == 9, "R3 first nine after clear", first, 9);
    check(second == 19, "R8 nine period", second, 19);
  endtask

  task automatic t_clr_set();
    int k9;
    set9 = 1; tick(); set9 = 0;
    check(nine == 1, "R4 set loads nine", nine, 1);
    clr = 1; set9 = 1; tick(); clr = 0; set9 = 0;
    check(nine == 0, "R4 clear wins over set", nine, 0);
    k9 = -1;
    for (int k = 1; k <= 9; k++) begin tick(); if (nine && k9 < 0) k9 = k; end
    check(k9 == 9, "R4 clear-wins state is zero", k9, 9);
  endtask

  task automatic t_inhibit();
    int pulses, k9;
    rate = 4'd9; clear_all();
    inh = 1; pulses = 0;
    for (int k = 0; k < 15; k++) begin tick(); pulses += int'(out); end
    check(pulses == 0, "R5 inhibit blanks output", pulses, 0);
    check(nine == 0 && inh_out == 1, "R5 inhibit holds state zero", nine, 0);
    inh = 0; k9 = -1;
    for (int k = 1; k <= 9; k++) begin tick(); if (nine && k9 < 0) k9 = k; end
    check(k9 == 9, "R5 counter frozen under inhibit", k9, 9);
    inh = 1; set9 = 1; tick(); set9 = 0;
    check(nine == 1 && inh_out == 1, "R9 carry held high by inhibit in", inh_out, 1);
    inh = 0; #1;
    check(inh_out == 0, "R9 carry low at nine", inh_out, 0);
    tick();
    check(nine == 0 && inh_out == 1, "R9 carry released after wrap", inh_out, 1);
  endtask

  task automatic t_strobe();
    int pulses, nines;
    rate = 4'd9; clear_all();
    strobe = 1; pulses = 0; nines = 0;
    for (int k = 0; k < 20; k++) begin tick(); pulses += int'(out); nines += int'(nine); end
    strobe = 0;
    check(pulses == 0, "R6 strobe blanks output", pulses, 0);
    check(nines == 2, "R6 counter runs under strobe", nines, 2);
  endtask

  task automatic t_cascade();
    rate = 4'd0; strobe = 1; inh = 1; cas = 1; tick();
    check(out == 1 && out_n == 0, "R7 cascade forces output high", {out, out_n}, 2);
    cas = 0; tick();
    check(out == 0, "R7 output drops after cascade", out, 0);
    strobe = 0; inh = 0;
  endtask

  task automatic t_chain();
    int total, lo_cnt, carries;
    rate = 4'd9; rate_lo = 4'd4; clear_all();
    total = 0; lo_cnt = 0; carries = 0;
    for (int k = 0; k < 100; k++) begin
      tick();
      total += int'(out | out_lo);
      lo_cnt += int'(out_lo);
      carries += int'(!inh_out_lo);
    end
    check(total == 94, "R9 two-decade add total", total, 94);
    check(lo_cnt == 4, "R9 low decade pulses", lo_cnt, 4);
    check(carries == 1, "R9 low decade carry once per 100", carries, 1);
    rate_lo = 4'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rate_sweep();
    t_slots();
    t_counter();
    t_clr_set();
    t_inhibit();
    t_strobe();
    t_cascade();
    t_chain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule